// File: doc/BRIEF.md
# Multiplication-Free Affine Triangle Warper

The block turns one right-angled triangular patch into a stream of coordinate pairs. Each pair gives a destination pixel inside the patch and the point in the reference frame its texture comes from. The patch is given by its right-angle corner, a power-of-two leg length, and a signed motion vector at each of its three corners. Corner 0 is the right angle. Corner 1 lies one leg along +x from it, and corner 2 lies one leg along +y from it. The source point is the destination plus the motion, interpolated affinely across the triangle.

After a start strobe, one cycle is spent deriving the six affine constants. The patch is treated as if its corner sat at the origin. The constants come from motion differences divided by the leg length, and that division is done with arithmetic right shifts. The block then walks the triangle one pixel per accepted transfer. Moving along a row adds one constant per axis to a fixed-point accumulator. Moving to the next row reloads the accumulators from a row base that has advanced by the row constants. No multiplier is used anywhere.

Results leave through a valid/ready stream. A pair is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the pair is held unchanged and the walk does not advance. `out_valid` never drops before its pair has been taken. `start` and `done` are plain control pins.

Top module: `affine_tri_warp`

## Requirements
- R1: After reset, `out_valid` and `done` are low.
- R2: A `start` sampled while idle captures all patch inputs. `out_valid` rises at the second clock edge after that sample. The first pair is dst = (org_x, org_y) and src = (org_x + mv0_x, org_y + mv0_y).
- R3: Let L = 2^leg_log2, and let (u, v) be the pixel offset from the corner. Pairs are emitted row by row, v = 0..L. Within a row, u runs 0..L−v, so only pixels with u + v ≤ L appear, (L+1)(L+2)/2 pairs in all. The destination is (org_x + u, org_y + v).
- R4: Fixed point uses 4 fractional bits. The x-axis constants are cx = 16 + floor(16·(mv1_x−mv0_x)/L) along a row and rx = floor(16·(mv2_x−mv0_x)/L) per row. The y-axis constants are cy = floor(16·(mv1_y−mv0_y)/L) along a row and ry = 16 + floor(16·(mv2_y−mv0_y)/L) per row. The x accumulator is 16·(org_x+mv0_x) + u·cx + v·rx, and the y accumulator is built the same way. The source coordinate is floor((acc + 8)/16), a signed value, and may be negative.
- R5: While `out_valid` is high and `out_ready` is low, all four output coordinates and `out_valid` stay unchanged into the next cycle.
- R6: `done` is high for exactly one cycle, the cycle after the edge that transfers the last pair. `out_valid` is low in that cycle.
- R7: A `start` asserted while a patch is in progress has no effect. The stream continues with the captured inputs, and no new patch begins.
- R8: Any leg_log2 from 0 to MAX_LOG2 (default 4) is accepted. With leg_log2 = 0 the patch gives exactly 3 pairs.
- R9: Motion vector components are 4-bit two's-complement values in −7..+7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a patch (honoured only when idle) |
| org_x | input | COORD_W | x of the right-angle corner |
| org_y | input | COORD_W | y of the right-angle corner |
| leg_log2 | input | LOG_W | log2 of the leg length |
| mv0_x | input | MV_W | Motion x at the right-angle corner (signed) |
| mv0_y | input | MV_W | Motion y at the right-angle corner (signed) |
| mv1_x | input | MV_W | Motion x at the +x corner (signed) |
| mv1_y | input | MV_W | Motion y at the +x corner (signed) |
| mv2_x | input | MV_W | Motion x at the +y corner (signed) |
| mv2_y | input | MV_W | Motion y at the +y corner (signed) |
| out_valid | output | 1 | Pair available |
| out_ready | input | 1 | Consumer accepts pair |
| dst_x | output | COORD_W | Destination x |
| dst_y | output | COORD_W | Destination y |
| src_x | output | COORD_W+2 | Source x (signed) |
| src_y | output | COORD_W+2 | Source y (signed) |
| done | output | 1 | One-cycle end-of-patch pulse |

## Verification
The bench drives inputs on falling edges and samples outputs on falling edges. After a start it expects `out_valid` low one falling edge later and high on the following one, matching the two registered steps, capture and then coefficient load. Each pair is compared with a bench model of R3/R4 at every falling edge where it is presented. When the bench holds ready low, the same expected pair is compared again on the next falling edge. `done` is expected high at the first falling edge after the last transfer and low at the one after that.

// File: rtl/warp_pkg.sv
package warp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COEF = 2'd1,
    ST_WALK = 2'd2,
    ST_DONE = 2'd3
  } warp_state_e;

  localparam int unsigned AXES = 2;
  localparam int unsigned CORNERS = 3;
endpackage

// File: rtl/warp_coef.sv
module warp_coef #(
  parameter int unsigned COORD_W = 8,
  parameter int unsigned MV_W    = 4,
  parameter int unsigned FRAC    = 4,
  parameter int unsigned LOG_W   = 3,
  parameter int unsigned ACC_W   = 15
) (
  input  logic [warp_pkg::AXES-1:0][COORD_W-1:0]                      org,
  input  logic [warp_pkg::CORNERS-1:0][warp_pkg::AXES-1:0][MV_W-1:0]  mv,
  input  logic [LOG_W-1:0]                                            leg_log2,
  output logic [warp_pkg::AXES-1:0][ACC_W-1:0]                        base,
  output logic [warp_pkg::AXES-1:0][ACC_W-1:0]                        ccol,
  output logic [warp_pkg::AXES-1:0][ACC_W-1:0]                        crow
);
  localparam logic signed [ACC_W-1:0] UNIT = ACC_W'(1 << FRAC);

  for (genvar a = 0; a < int'(warp_pkg::AXES); a++) begin : g_axis
    logic signed [ACC_W-1:0] m0, m1, m2, d1, d2, q1, q2, org_s;
    assign m0    = {{(ACC_W-MV_W){mv[0][a][MV_W-1]}}, mv[0][a]};
    assign m1    = {{(ACC_W-MV_W){mv[1][a][MV_W-1]}}, mv[1][a]};
    assign m2    = {{(ACC_W-MV_W){mv[2][a][MV_W-1]}}, mv[2][a]};
    assign org_s = {{(ACC_W-COORD_W){1'b0}}, org[a]};
    assign d1    = m1 - m0;
    assign d2    = m2 - m0;
    // divide by the power-of-two leg with an arithmetic shift
    assign q1    = (d1 <<< FRAC) >>> leg_log2;
    assign q2    = (d2 <<< FRAC) >>> leg_log2;
    assign base[a] = (org_s + m0) <<< FRAC;
    if (a == 0) begin : g_x
      assign ccol[a] = q1 + UNIT;
      assign crow[a] = q2;
    end else begin : g_y
      assign ccol[a] = q1;
      assign crow[a] = q2 + UNIT;
    end
  end
endmodule

// File: rtl/warp_axis_acc.sv
module warp_axis_acc #(
  parameter int unsigned ACC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_col,
  input  logic             step_row,
  input  logic [ACC_W-1:0] base,
  input  logic [ACC_W-1:0] ccol_in,
  input  logic [ACC_W-1:0] crow_in,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] ccol_q, crow_q, row_q, acc_q;
  logic [ACC_W-1:0] row_next;

  assign row_next = row_q + crow_q;
  assign acc_o    = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccol_q <= '0;
      crow_q <= '0;
      row_q  <= '0;
      acc_q  <= '0;
    end else if (load) begin
      ccol_q <= ccol_in;
      crow_q <= crow_in;
      row_q  <= base;
      acc_q  <= base;
    end else if (step_row) begin
      row_q  <= row_next;
      acc_q  <= row_next;
    end else if (step_col) begin
      acc_q  <= acc_q + ccol_q;
    end
  end
endmodule

// File: rtl/warp_ctrl.sv
module warp_ctrl #(
  parameter int unsigned LOG_W = 3,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LOG_W-1:0] leg_log2,
  input  logic             out_ready,
  output logic             capture,
  output logic             load,
  output logic             step_col,
  output logic             step_row,
  output logic             out_valid,
  output logic             done,
  output logic             busy,
  output logic [CNT_W-1:0] u,
  output logic [CNT_W-1:0] v
);
  import warp_pkg::*;

  warp_state_e state_q;
  logic [CNT_W-1:0] leg;
  logic [CNT_W:0]   diag;
  logic             fire, row_end, last;

  assign leg      = CNT_W'(1) << leg_log2;
  assign diag     = {1'b0, u} + {1'b0, v};
  assign row_end  = (diag == {1'b0, leg});
  assign out_valid = (state_q == ST_WALK);
  assign done      = (state_q == ST_DONE);
  assign busy      = (state_q != ST_IDLE);
  assign capture   = (state_q == ST_IDLE) && start;
  assign load      = (state_q == ST_COEF);
  assign fire      = out_valid && out_ready;
  assign step_col  = fire && !row_end;
  assign step_row  = fire && row_end && (v != leg);
  assign last      = fire && row_end && (v == leg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      u       <= '0;
      v       <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_COEF;
        ST_COEF: begin
          u       <= '0;
          v       <= '0;
          state_q <= ST_WALK;
        end
        ST_WALK: begin
          if (last) begin
            state_q <= ST_DONE;
          end else if (step_row) begin
            u <= '0;
            v <= v + 1'b1;
          end else if (step_col) begin
            u <= u + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  inside_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (diag <= {1'b0, leg}));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> done);
endmodule

// File: rtl/affine_tri_warp.sv
module affine_tri_warp #(
  parameter int unsigned COORD_W  = 8,
  parameter int unsigned MV_W     = 4,
  parameter int unsigned FRAC     = 4,
  parameter int unsigned MAX_LOG2 = 4,
  localparam int unsigned LOG_W   = $clog2(MAX_LOG2 + 1),
  localparam int unsigned CNT_W   = MAX_LOG2 + 1,
  localparam int unsigned ACC_W   = COORD_W + FRAC + 3,
  localparam int unsigned SRC_W   = COORD_W + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [COORD_W-1:0]        org_x,
  input  logic [COORD_W-1:0]        org_y,
  input  logic [LOG_W-1:0]          leg_log2,
  input  logic signed [MV_W-1:0]    mv0_x,
  input  logic signed [MV_W-1:0]    mv0_y,
  input  logic signed [MV_W-1:0]    mv1_x,
  input  logic signed [MV_W-1:0]    mv1_y,
  input  logic signed [MV_W-1:0]    mv2_x,
  input  logic signed [MV_W-1:0]    mv2_y,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [COORD_W-1:0]        dst_x,
  output logic [COORD_W-1:0]        dst_y,
  output logic signed [SRC_W-1:0]   src_x,
  output logic signed [SRC_W-1:0]   src_y,
  output logic                      done
);
  import warp_pkg::*;

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC - 1));

  logic [AXES-1:0][COORD_W-1:0]             org_q;
  logic [CORNERS-1:0][AXES-1:0][MV_W-1:0]   mv_q;
  logic [LOG_W-1:0]                         leg_q;
  logic [AXES-1:0][ACC_W-1:0]               base, ccol, crow, acc;
  logic [AXES-1:0][SRC_W-1:0]               src;
  logic                                     capture, load, step_col, step_row, busy;
  logic [CNT_W-1:0]                         u, v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      org_q <= '0;
      mv_q  <= '0;
      leg_q <= '0;
    end else if (capture) begin
      org_q <= {org_y, org_x};
      mv_q  <= {mv2_y, mv2_x, mv1_y, mv1_x, mv0_y, mv0_x};
      leg_q <= leg_log2;
    end
  end

  warp_ctrl #(.LOG_W(LOG_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .leg_log2(leg_q),
    .out_ready(out_ready), .capture(capture), .load(load),
    .step_col(step_col), .step_row(step_row), .out_valid(out_valid),
    .done(done), .busy(busy), .u(u), .v(v)
  );

  warp_coef #(.COORD_W(COORD_W), .MV_W(MV_W), .FRAC(FRAC), .LOG_W(LOG_W),
              .ACC_W(ACC_W)) u_coef (
    .org(org_q), .mv(mv_q), .leg_log2(leg_q),
    .base(base), .ccol(ccol), .crow(crow)
  );

  for (genvar a = 0; a < int'(AXES); a++) begin : g_acc
    logic signed [ACC_W-1:0] rnd;
    warp_axis_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .load(load), .step_col(step_col),
      .step_row(step_row), .base(base[a]), .ccol_in(ccol[a]),
      .crow_in(crow[a]), .acc_o(acc[a])
    );
    assign rnd    = $signed(acc[a]) + HALF;
    assign src[a] = SRC_W'(rnd >>> FRAC);
  end

  assign src_x = $signed(src[0]);
  assign src_y = $signed(src[1]);
  assign dst_x = org_q[0] + COORD_W'(u);
  assign dst_y = org_q[1] + COORD_W'(v);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(src_x) && $stable(src_y)
                                   && $stable(dst_x) && $stable(dst_y)));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(leg_q) && $stable(org_q) && $stable(mv_q)));
endmodule

// File: tb/tb_affine_tri_warp.sv
module tb_affine_tri_warp;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [7:0] org_x = 0, org_y = 0;
  logic [2:0] leg_log2 = 0;
  logic signed [3:0] mv0_x = 0, mv0_y = 0, mv1_x = 0, mv1_y = 0, mv2_x = 0, mv2_y = 0;
  logic out_valid, out_ready = 0, done;
  logic [7:0] dst_x, dst_y;
  logic signed [9:0] src_x, src_y;

  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  affine_tri_warp dut (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .leg_log2(leg_log2), .mv0_x(mv0_x), .mv0_y(mv0_y), .mv1_x(mv1_x),
    .mv1_y(mv1_y), .mv2_x(mv2_x), .mv2_y(mv2_y), .out_valid(out_valid),
    .out_ready(out_ready), .dst_x(dst_x), .dst_y(dst_y), .src_x(src_x),
    .src_y(src_y), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // source model per R4
  function automatic int model_src(input int org, input int m0, input int m1, input int m2,
                                   input int k, input int u, input int v, input bit is_x);
    int cc, cr, acc;
    cc  = (((m1 - m0) * 16) >>> k) + (is_x ? 16 : 0);
    cr  = (((m2 - m0) * 16) >>> k) + (is_x ? 0 : 16);
    acc = (org + m0) * 16 + u * cc + v * cr;
    return (acc + 8) >>> 4;
  endfunction

  task automatic run_patch(input int ox, input int oy, input int k,
                           input int a0x, input int a0y, input int a1x, input int a1y,
                           input int a2x, input int a2y, input int stall_pct, input bit poke);
    int leg, idx;
    leg = 1 << k;
    idx = 0;
    @(negedge clk);
    org_x = 8'(ox); org_y = 8'(oy); leg_log2 = 3'(k);
    mv0_x = 4'(a0x); mv0_y = 4'(a0y); mv1_x = 4'(a1x);
    mv1_y = 4'(a1y); mv2_x = 4'(a2x); mv2_y = 4'(a2y);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 valid one cycle after start", int'(out_valid), 0);
    @(negedge clk);
    chk("R2 valid two cycles after start", int'(out_valid), 1);
    for (int v = 0; v <= leg; v++) begin
      for (int u = 0; u <= leg - v; u++) begin
        bit got;
        got = 0;
        while (!got) begin
          if (!out_valid) begin
            chk("R3 stream ended early", 0, 1);
            got = 1;
          end else begin
            chk("R3 dst_x", int'(dst_x), ox + u);
            chk("R3 dst_y", int'(dst_y), oy + v);
            chk("R4 src_x", int'(src_x), model_src(ox, a0x, a1x, a2x, k, u, v, 1'b1));
            chk("R4 src_y", int'(src_y), model_src(oy, a0y, a1y, a2y, k, u, v, 1'b0));
            out_ready = (int'($urandom_range(99)) >= stall_pct);
            if (poke && idx == 2) begin
              // R7: restart attempt with different inputs while busy
              start = 1; org_x = 8'd3; org_y = 8'd5; leg_log2 = 3'd1;
              mv0_x = 4'sd7; mv1_y = -4'sd7;
            end
            @(negedge clk);
            start = 0;
            got = out_ready;
          end
        end
        idx++;
      end
    end
    out_ready = 0;
    chk("R6 done after last pair", int'(done), 1);
    chk("R6 valid low at done", int'(out_valid), 0);
    @(negedge clk);
    chk("R6 done one cycle only", int'(done), 0);
    chk("R7 no new patch started", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R1 out_valid at reset", int'(out_valid), 0);
    chk("R1 done at reset", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 done after reset", int'(done), 0);

    // R8: smallest patch, 3 pairs
    run_patch(10, 20, 0, 1, -2, 3, 4, -5, 6, 0, 0);
    // identity motion at largest leg: src equals dst
    run_patch(100, 50, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: extreme signed motion values
    run_patch(2, 1, 3, -7, -7, 7, 7, 7, -7, 30, 0);
    run_patch(60, 70, 2, 7, 7, -7, -7, -7, 7, 60, 0);
    // R5: heavy back-pressure
    run_patch(30, 40, 3, 3, -1, -4, 2, 5, -6, 85, 0);
    // R7: start while busy is ignored
    run_patch(80, 90, 3, 2, 3, -3, 1, 4, -2, 20, 1);

    for (int t = 0; t < 30; t++) begin
      run_patch(int'($urandom_range(200)), int'($urandom_range(200)),
                int'($urandom_range(4)),
                int'($urandom_range(14)) - 7, int'($urandom_range(14)) - 7,
                int'($urandom_range(14)) - 7, int'($urandom_range(14)) - 7,
                int'($urandom_range(14)) - 7, int'($urandom_range(14)) - 7,
                int'($urandom_range(50)), t[2]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule